// File: doc/BRIEF.md
# Accumulator Round-Saturate-Store Unit

This block prepares a wide signed accumulator for writing into a narrow memory word. It takes the 40-bit accumulator, scales it by a signed shift code, optionally rounds it at the boundary of the word being kept, and picks the 16-bit slice that holds bits 31 down to 16 of the result. When saturate-on-store is enabled, a value whose integer part does not fit the word is replaced by the nearest limit. A flag reports that this replacement took place.

The accumulator is only read. Every transform acts on a private copy inside the unit, so the value held in the accumulator register upstream never changes. The unit has one register stage. A request presented with `in_valid` produces `out_valid`, `word_out` and `sat_flag` on the following clock edge. The sign-extension mode decides whether the stored word is read as signed (limits 0x7FFF and 0x8000) or as unsigned (limits 0xFFFF and 0x0000).

Top module: `accst_store_unit`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `out_valid`, `word_out` and `sat_flag` are all zero.
- R2: A request sampled with `in_valid` high gives `out_valid` high on the next clock edge. A cycle with `in_valid` low gives `out_valid` low on the next edge.
- R3: With shift code 0 and rounding and saturation disabled, `word_out` equals accumulator bits [31:16].
- R4: The shift code is a two's-complement 6-bit value. A positive code shifts left. A negative code shifts right arithmetically and keeps the sign. Codes below -16 act as -16, and codes above +15 act as +15. The shift is applied before rounding.
- R5: With `rnd_en`=1 and `rnd_even`=0, 0x8000 is added to the shifted value and bits [15:0] are then cleared.
- R6: With `rnd_en`=1 and `rnd_even`=1, a value whose bits [15:0] are exactly 0x8000 rounds to the even result: bit 16 is cleared after the add. Any other value rounds as in R5.
- R7: With `rnd_en`=0, the bits below bit 16 are dropped without rounding.
- R8: With `sat_en`=1 and `sign_ext`=1, an integer part (value >>> 16) above 32767 stores 0x7FFF, and one below -32768 stores 0x8000.
- R9: With `sat_en`=1 and `sign_ext`=0, an integer part above 65535 stores 0xFFFF, and a negative integer part stores 0x0000.
- R10: With `sat_en`=0, no saturation occurs. The word is the wrapped slice [31:16], and `sat_flag` is 0.
- R11: `sat_flag` is 1 exactly when the stored word differs from the unsaturated slice [31:16] of the shifted and rounded value. It is never 1 while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| acc_in | input | 40 | Accumulator value, two's complement |
| shift_amt | input | 6 | Signed shift code, positive means left |
| rnd_en | input | 1 | Enable rounding at bit 15 |
| rnd_even | input | 1 | 0 biased rounding, 1 round half to even |
| sat_en | input | 1 | Enable saturation of the stored word |
| sign_ext | input | 1 | 1 signed limits, 0 unsigned limits |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| word_out | output | 16 | Word to be written |
| sat_flag | output | 1 | The stored word was replaced by a limit |

## Verification
The hardest case to reach is the even-rounding tie. Bits [15:0] must equal 0x8000 after the shift, so the tie must be built through the shifter as well as written in directly. The stimulus places the tie both in the raw accumulator and at a position a right or left shift moves onto bit 15. It also drives a tie just below the positive limit, so that rounding alone carries the value into saturation. A stream of random requests with random mode bits is then checked against a behavioural model in the bench on every clock.

// File: rtl/accst_pkg.sv
package accst_pkg;

    parameter int ACC_W_DEF   = 40;
    parameter int WORD_W_DEF  = 16;
    parameter int SH_W_DEF    = 6;
    parameter int LSH_MAX_DEF = 15;
    parameter int RSH_MAX_DEF = 16;

    // Per-request control bits carried together through the datapath
    typedef struct packed {
        logic rnd_en;
        logic rnd_even;
        logic sat_en;
        logic signed_mode;
    } store_mode_t;

    // Limit a signed shift request to the supported window
    function automatic int clamp_shift(input int amt, input int lo, input int hi);
        if (amt < lo)
            return lo;
        else if (amt > hi)
            return hi;
        else
            return amt;
    endfunction

endpackage

// File: rtl/accst_shift.sv
module accst_shift
    import accst_pkg::*;
#(
    parameter int ACC_W   = ACC_W_DEF,
    parameter int SH_W    = SH_W_DEF,
    parameter int LSH_MAX = LSH_MAX_DEF,
    parameter int RSH_MAX = RSH_MAX_DEF
) (
    input  logic [ACC_W-1:0]         acc_i,
    input  logic [SH_W-1:0]          amt_i,
    output logic [ACC_W+LSH_MAX:0]   val_o
);
    localparam int WIDE_W = ACC_W + LSH_MAX + 1;

    logic [WIDE_W-1:0] wide;

    always_comb begin
        int a;
        a     = clamp_shift(int'($signed(amt_i)), -RSH_MAX, LSH_MAX);
        wide  = {{(WIDE_W-ACC_W){acc_i[ACC_W-1]}}, acc_i};
        if (a >= 0)
            val_o = wide << a;
        else
            val_o = $signed(wide) >>> (-a);
    end

endmodule

// File: rtl/accst_round.sv
module accst_round #(
    parameter int WIDE_W = 56,
    parameter int FRAC_W = 16
) (
    input  logic [WIDE_W-1:0] val_i,
    input  logic              en_i,
    input  logic              even_i,
    output logic [WIDE_W-1:0] val_o,
    output logic              tie_o
);
    localparam logic [WIDE_W-1:0] HALF = WIDE_W'(1) << (FRAC_W - 1);

    logic [WIDE_W-1:0] sum;

    always_comb begin
        tie_o = (val_i[FRAC_W-1:0] == HALF[FRAC_W-1:0]);
        sum   = val_i + HALF;
        sum[FRAC_W-1:0] = '0;
        if (even_i && tie_o)
            sum[FRAC_W] = 1'b0;
        val_o = en_i ? sum : val_i;
    end

endmodule

// File: rtl/accst_sat.sv
module accst_sat #(
    parameter int WIDE_W = 56,
    parameter int FRAC_W = 16,
    parameter int WORD_W = 16
) (
    input  logic [WIDE_W-1:0] val_i,
    input  logic              sat_en_i,
    input  logic              signed_i,
    output logic [WORD_W-1:0] word_o,
    output logic              hit_o
);
    localparam int IP_W = WIDE_W - FRAC_W;

    logic [IP_W-1:0]   ip;
    logic [WORD_W-1:0] raw;
    logic              s_fits;
    logic              u_fits;

    always_comb begin
        ip     = val_i[WIDE_W-1:FRAC_W];
        raw    = ip[WORD_W-1:0];
        s_fits = (~|ip[IP_W-1:WORD_W-1]) || (&ip[IP_W-1:WORD_W-1]);
        u_fits = ~|ip[IP_W-1:WORD_W];
        word_o = raw;
        if (sat_en_i) begin
            if (signed_i) begin
                if (!s_fits)
                    word_o = ip[IP_W-1] ? {1'b1, {(WORD_W-1){1'b0}}}
                                        : {1'b0, {(WORD_W-1){1'b1}}};
            end else begin
                if (!u_fits)
                    word_o = ip[IP_W-1] ? '0 : '1;
            end
        end
        hit_o = (word_o != raw);
    end

endmodule

// File: rtl/accst_store_unit.sv
module accst_store_unit
    import accst_pkg::*;
#(
    parameter int ACC_W   = ACC_W_DEF,
    parameter int WORD_W  = WORD_W_DEF,
    parameter int SH_W    = SH_W_DEF,
    parameter int LSH_MAX = LSH_MAX_DEF,
    parameter int RSH_MAX = RSH_MAX_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [SH_W-1:0]   shift_amt,
    input  logic              rnd_en,
    input  logic              rnd_even,
    input  logic              sat_en,
    input  logic              sign_ext,
    output logic              out_valid,
    output logic [WORD_W-1:0] word_out,
    output logic              sat_flag
);
    localparam int WIDE_W = ACC_W + LSH_MAX + 1;
    localparam int FRAC_W = WORD_W;

    store_mode_t       mode;
    logic [WIDE_W-1:0] shifted;
    logic [WIDE_W-1:0] rounded;
    logic              tie;
    logic [WORD_W-1:0] word_nxt;
    logic              hit_nxt;

    assign mode = '{rnd_en: rnd_en, rnd_even: rnd_even,
                    sat_en: sat_en, signed_mode: sign_ext};

    accst_shift #(
        .ACC_W(ACC_W), .SH_W(SH_W), .LSH_MAX(LSH_MAX), .RSH_MAX(RSH_MAX)
    ) u_shift (
        .acc_i (acc_in),
        .amt_i (shift_amt),
        .val_o (shifted)
    );

    accst_round #(
        .WIDE_W(WIDE_W), .FRAC_W(FRAC_W)
    ) u_round (
        .val_i  (shifted),
        .en_i   (mode.rnd_en),
        .even_i (mode.rnd_even),
        .val_o  (rounded),
        .tie_o  (tie)
    );

    accst_sat #(
        .WIDE_W(WIDE_W), .FRAC_W(FRAC_W), .WORD_W(WORD_W)
    ) u_sat (
        .val_i    (rounded),
        .sat_en_i (mode.sat_en),
        .signed_i (mode.signed_mode),
        .word_o   (word_nxt),
        .hit_o    (hit_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            word_out  <= '0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                word_out <= word_nxt;
                sat_flag <= hit_nxt;
            end else begin
                sat_flag <= 1'b0;
            end
        end
    end

    // R2: result strobe follows the request strobe by one edge
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_latency_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6: a tie under even rounding never leaves bit 16 set
    assert_tie_even_R6: assert property (@(posedge clk) disable iff (rst)
        (rnd_en && rnd_even && tie) |-> !rounded[FRAC_W]);

    // R8: signed replacement only ever yields the signed limits
    assert_signed_limit_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sat_flag && $past(sign_ext)) |->
        (word_out == {1'b0, {(WORD_W-1){1'b1}}} || word_out == {1'b1, {(WORD_W-1){1'b0}}}));

    // R9: unsigned replacement only ever yields the unsigned limits
    assert_unsigned_limit_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sat_flag && !$past(sign_ext)) |->
        (word_out == '1 || word_out == '0));

    // R10: saturation disabled means no flag
    assert_no_sat_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(sat_en)) |-> !sat_flag);

    // R11: flag only accompanies a valid result
    assert_flag_needs_valid_R11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !sat_flag);

endmodule

// File: tb/accst_store_unit_tb.sv
`timescale 1ns/1ps
module accst_store_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [39:0] acc_in;
    logic [5:0]  shift_amt;
    logic        rnd_en, rnd_even, sat_en, sign_ext;
    logic        out_valid;
    logic [15:0] word_out;
    logic        sat_flag;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    accst_store_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .acc_in(acc_in),
        .shift_amt(shift_amt), .rnd_en(rnd_en), .rnd_even(rnd_even),
        .sat_en(sat_en), .sign_ext(sign_ext), .out_valid(out_valid),
        .word_out(word_out), .sat_flag(sat_flag)
    );

    // Behavioural model of the requirements
    task automatic model(input logic [39:0] a, input logic [5:0] s,
                         input bit re, input bit rm, input bit se, input bit sx,
                         output logic [15:0] w, output bit f);
        longint v, hi;
        int sh;
        bit tie;
        logic [15:0] raw;
        v  = longint'($signed(a));
        sh = int'($signed(s));
        if (sh < -16) sh = -16;
        if (sh > 15)  sh = 15;
        if (sh >= 0) v = v <<< sh;
        else         v = v >>> (-sh);
        if (re) begin
            tie = ((v & 64'hFFFF) == 64'h8000);
            v   = (v + 64'h8000) & ~64'hFFFF;
            if (rm && tie) v = v & ~64'h10000;
        end
        hi  = v >>> 16;
        raw = hi[15:0];
        w   = raw;
        if (se) begin
            if (sx) begin
                if (hi > 32767)       w = 16'h7FFF;
                else if (hi < -32768) w = 16'h8000;
            end else begin
                if (hi > 65535)       w = 16'hFFFF;
                else if (hi < 0)      w = 16'h0000;
            end
        end
        f = (w != raw);
    endtask

    task automatic check1(input string tag, input string what,
                          input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run(input logic [39:0] a, input logic [5:0] s,
                       input bit re, input bit rm, input bit se, input bit sx,
                       input string tag);
        logic [15:0] ew;
        bit ef;
        @(negedge clk);
        in_valid = 1'b1; acc_in = a; shift_amt = s;
        rnd_en = re; rnd_even = rm; sat_en = se; sign_ext = sx;
        model(a, s, re, rm, se, sx, ew, ef);
        @(negedge clk);
        in_valid = 1'b0;
        check1(tag, "out_valid", longint'(out_valid), 1);
        check1(tag, "word_out", longint'(word_out), longint'(ew));
        check1(tag, "sat_flag", longint'(sat_flag), longint'(ef));
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; acc_in = '0; shift_amt = '0;
        rnd_en = 0; rnd_even = 0; sat_en = 0; sign_ext = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check1("R1", "out_valid", longint'(out_valid), 0);
        check1("R1", "word_out", longint'(word_out), 0);
        check1("R1", "sat_flag", longint'(sat_flag), 0);
        rst = 1'b0;

        // R3 plain slice
        run(40'h00_1234_5678, 6'd0, 0, 0, 0, 1, "R3");
        run(40'hFF_ABCD_0001, 6'd0, 0, 0, 0, 1, "R3");
        // R2 idle cycle gives no strobe
        @(negedge clk);
        check1("R2", "out_valid idle", longint'(out_valid), 0);
        // R4 shifting and clamping
        run(40'h00_0000_1234, 6'd8, 0, 0, 0, 1, "R4");
        run(40'hFF_8000_0000, 6'h3C, 0, 0, 0, 1, "R4");   // -4
        run(40'h12_3456_0000, 6'h20, 0, 0, 0, 1, "R4");   // -32 acts as -16
        run(40'h00_0000_0001, 6'd31, 0, 0, 0, 1, "R4");   // +31 acts as +15
        run(40'h00_0123_4800, 6'd4, 1, 1, 0, 1, "R4");    // shift then tie
        // R5 biased rounding
        run(40'h00_1234_8000, 6'd0, 1, 0, 0, 1, "R5");
        run(40'h00_1234_7FFF, 6'd0, 1, 0, 0, 1, "R5");
        // R6 half to even
        run(40'h00_1234_8000, 6'd0, 1, 1, 0, 1, "R6");
        run(40'h00_1235_8000, 6'd0, 1, 1, 0, 1, "R6");
        run(40'h00_1234_8001, 6'd0, 1, 1, 0, 1, "R6");
        run(40'h00_2469_0000, 6'h3F, 1, 1, 0, 1, "R6");   // right 1 lands on tie
        // R7 truncation
        run(40'h00_1234_FFFF, 6'd0, 0, 1, 0, 1, "R7");
        // R8 signed limits
        run(40'h00_8000_0000, 6'd0, 0, 0, 1, 1, "R8");
        run(40'hFF_7FFF_FFFF, 6'd0, 0, 0, 1, 1, "R8");
        run(40'h00_7FFF_0000, 6'd0, 0, 0, 1, 1, "R8");
        run(40'h00_7FFF_8000, 6'd0, 1, 0, 1, 1, "R8");
        // R9 unsigned limits
        run(40'h00_FFFF_0000, 6'd0, 0, 0, 1, 0, "R9");
        run(40'h01_0000_0000, 6'd0, 0, 0, 1, 0, "R9");
        run(40'hFF_FFFF_0000, 6'd0, 0, 0, 1, 0, "R9");
        // R10 saturation disabled wraps
        run(40'h00_8000_0000, 6'd0, 0, 0, 0, 1, "R10");
        run(40'h01_0000_0000, 6'd0, 0, 0, 0, 0, "R10");
        // R11 random mix against the model
        for (int i = 0; i < 300; i++) begin
            logic [63:0] r;
            r = {$urandom, $urandom};
            run(r[39:0], 6'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), "R11");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule